// File: doc/BRIEF.md
# Table Access Pointer and Latch Unit

This unit connects a small processor core to a byte-addressed program memory for table-style data moves. The core loads a 22-bit pointer through three byte-wide registers and an 8-bit latch. It then issues read or write operations, and each one carries a pointer-update mode. A read fetches the addressed byte into the latch. A write copies the latch into one of eight holding registers, and the low pointer bits choose which one.

The unit also supplies the block addresses that the flash sequencer needs. When the sequencer is told to program, it receives the 8-byte block address and the eight holding bytes, and the holding registers then refill with 0xFF. When it is told to erase, it receives the 64-byte block address. Only the low 21 pointer bits move under the update modes. Bit 21 switches between the main array and the configuration/identification space, and it changes only when the core writes it.

Top module: `tbl_ptr_unit`

## Requirements
- R1: After reset the pointer and the latch read zero, every holding byte reads 0xFF, and busy is low.
- R2: While the unit is idle and op_req is low, a write with reg_sel 0, 1 or 2 loads pointer bits 7:0, 15:8 or 21:16 (the last from reg_wdata[5:0]), and reg_sel 3 loads the latch. Such writes are ignored while busy is high.
- R3: op_mode 0 leaves the pointer unchanged, 1 increments it after the access, 2 decrements it after the access, and 3 increments it before the access. Modes 0 to 2 access the old pointer value, and mode 3 accesses the incremented value.
- R4: Increments and decrements act only on bits 20:0 and wrap within 21 bits. Bit 21 keeps its value.
- R5: A request seen while the unit is idle makes busy high for exactly one cycle, and requests seen during that cycle are ignored. For a read (op_is_write 0), mem_rd_en is high during the busy cycle and mem_rd_addr carries all 22 access bits. In the next cycle the latch holds mem_rd_data and rd_valid is high.
- R6: A write (op_is_write 1) stores the latch in the holding register indexed by access address bits 2:0 and does not raise rd_valid.
- R7: lwr_start while the unit is idle and op_req is low raises lwr_issue in the same cycle. lwr_block_addr is pointer bits 21:3, and lwr_data carries holding byte i in bits 8i+7:8i. From the next cycle every holding byte is 0xFF.
- R8: erase_start raises erase_issue in the same cycle, with erase_block_addr equal to pointer bits 21:6. The priority order is op_req, then lwr_start, then erase_start, so at most one of them is taken.
- R9: The final pointer value, after every mode, can be read in the cycle after the busy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Core register write strobe |
| reg_sel | input | 2 | 0 ptr low, 1 ptr high, 2 ptr upper, 3 latch |
| reg_wdata | input | 8 | Core register write data |
| ptr_o | output | 22 | Current pointer |
| latch_o | output | 8 | Current latch |
| op_req | input | 1 | Table operation request |
| op_is_write | input | 1 | 1 table write, 0 table read |
| op_mode | input | 2 | Pointer-update mode |
| busy | output | 1 | Operation in progress |
| mem_rd_en | output | 1 | Program memory read strobe |
| mem_rd_addr | output | 22 | Program memory byte address |
| mem_rd_data | input | 8 | Program memory read data (same cycle) |
| rd_valid | output | 1 | Latch freshly loaded by a read |
| lwr_start | input | 1 | Sequencer request to program a block |
| lwr_issue | output | 1 | Program block request taken |
| lwr_block_addr | output | 19 | 8-byte block address |
| lwr_data | output | 64 | Holding register contents |
| erase_start | input | 1 | Sequencer request to erase a block |
| erase_issue | output | 1 | Erase request taken |
| erase_block_addr | output | 16 | 64-byte block address |

## Verification
The program and erase outputs are combinational, so the bench drives their start inputs and samples the outputs in the same cycle. The holding-register refill is checked one cycle later. For a table operation, the access address appears in the busy cycle, one edge after the request. The latch, rd_valid and the final pointer are settled one edge after that. The bench drives on falling edges and samples at exactly those falling edges, so each check falls midway through the cycle in which its result is due.

// File: rtl/tpu_pkg.sv
`timescale 1ns/1ps
package tpu_pkg;
  typedef enum logic [1:0] {
    PM_HOLD    = 2'd0,
    PM_POSTINC = 2'd1,
    PM_POSTDEC = 2'd2,
    PM_PREINC  = 2'd3
  } ptr_mode_e;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_ACCESS = 1'b1
  } tpu_state_e;
endpackage

// File: rtl/tpu_ptr.sv
`timescale 1ns/1ps
module tpu_ptr #(
  parameter int PTR_W  = 22,
  parameter int DATA_W = 8,
  localparam int NBYTES = (PTR_W + DATA_W - 1) / DATA_W,
  localparam int WRAP_W = PTR_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NBYTES-1:0] byte_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              step_en,
  input  logic              step_down,
  output logic [PTR_W-1:0]  ptr_q,
  output logic [PTR_W-1:0]  ptr_up
);
  logic [PTR_W-1:0]  ptr_nxt;
  logic [WRAP_W-1:0] wrap_inc;
  logic [WRAP_W-1:0] wrap_dec;

  assign wrap_inc = ptr_q[WRAP_W-1:0] + 1'b1;
  assign wrap_dec = ptr_q[WRAP_W-1:0] - 1'b1;
  assign ptr_up   = {ptr_q[PTR_W-1], wrap_inc};

  always_comb begin
    ptr_nxt = ptr_q;
    if (step_en) begin
      ptr_nxt[WRAP_W-1:0] = step_down ? wrap_dec : wrap_inc;
    end else begin
      for (int i = 0; i < PTR_W; i++) begin
        if (byte_we[i / DATA_W]) ptr_nxt[i] = wdata[i % DATA_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_nxt;
  end
endmodule

// File: rtl/tpu_hold.sv
`timescale 1ns/1ps
module tpu_hold #(
  parameter int HOLD_N = 8,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(HOLD_N)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     refill,
  output logic [HOLD_N*DATA_W-1:0] bank
);
  for (genvar g = 0; g < HOLD_N; g++) begin : g_ent
    logic [DATA_W-1:0] ent_q;
    logic [DATA_W-1:0] ent_nxt;

    always_comb begin
      ent_nxt = ent_q;
      if (refill)                                     ent_nxt = '1;
      else if (wr_en && (wr_idx == IDX_W'(g)))        ent_nxt = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q <= '1;
      else        ent_q <= ent_nxt;
    end

    assign bank[g*DATA_W +: DATA_W] = ent_q;
  end
endmodule

// File: rtl/tpu_ctrl.sv
`timescale 1ns/1ps
module tpu_ctrl
  import tpu_pkg::*;
#(
  parameter int PTR_W  = 22,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_req,
  input  logic              op_is_write,
  input  logic [1:0]        op_mode,
  input  logic [PTR_W-1:0]  ptr_q,
  input  logic [PTR_W-1:0]  ptr_up,
  input  logic [DATA_W-1:0] mem_rd_data,
  input  logic              latch_we,
  input  logic [DATA_W-1:0] latch_wdata,
  output logic              idle,
  output logic [PTR_W-1:0]  acc_addr,
  output logic              mem_rd_en,
  output logic              rd_valid,
  output logic              hold_we,
  output logic [IDX_W-1:0]  hold_idx,
  output logic              step_en,
  output logic              step_down,
  output logic [DATA_W-1:0] latch
);
  tpu_state_e        state_q, state_nxt;
  ptr_mode_e         mode_q, mode_nxt, mode_in;
  logic              wr_q, wr_nxt;
  logic [PTR_W-1:0]  acc_q, acc_nxt;
  logic              valid_q, valid_nxt;
  logic [DATA_W-1:0] latch_q, latch_nxt;
  logic              accept;
  logic              in_access;

  assign mode_in   = ptr_mode_e'(op_mode);
  assign idle      = (state_q == ST_IDLE);
  assign in_access = (state_q == ST_ACCESS);
  assign accept    = op_req && idle;

  assign step_en   = (accept && mode_in == PM_PREINC) ||
                     (in_access && (mode_q == PM_POSTINC || mode_q == PM_POSTDEC));
  assign step_down = in_access && (mode_q == PM_POSTDEC);

  always_comb begin
    state_nxt = state_q;
    mode_nxt  = mode_q;
    wr_nxt    = wr_q;
    acc_nxt   = acc_q;
    latch_nxt = latch_q;
    valid_nxt = in_access && !wr_q;
    if (accept) begin
      state_nxt = ST_ACCESS;
      mode_nxt  = mode_in;
      wr_nxt    = op_is_write;
      acc_nxt   = (mode_in == PM_PREINC) ? ptr_up : ptr_q;
    end else if (in_access) begin
      state_nxt = ST_IDLE;
    end
    if (in_access && !wr_q) latch_nxt = mem_rd_data;
    else if (latch_we)      latch_nxt = latch_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= PM_HOLD;
      wr_q    <= 1'b0;
      acc_q   <= '0;
      valid_q <= 1'b0;
      latch_q <= '0;
    end else begin
      state_q <= state_nxt;
      mode_q  <= mode_nxt;
      wr_q    <= wr_nxt;
      acc_q   <= acc_nxt;
      valid_q <= valid_nxt;
      latch_q <= latch_nxt;
    end
  end

  assign acc_addr  = acc_q;
  assign mem_rd_en = in_access && !wr_q;
  assign rd_valid  = valid_q;
  assign hold_we   = in_access && wr_q;
  assign hold_idx  = acc_q[IDX_W-1:0];
  assign latch     = latch_q;
endmodule

// File: rtl/tbl_ptr_unit.sv
`timescale 1ns/1ps
module tbl_ptr_unit #(
  parameter int PTR_W       = 22,
  parameter int DATA_W      = 8,
  parameter int HOLD_N      = 8,
  parameter int ERASE_BYTES = 64,
  localparam int HOLD_AW  = $clog2(HOLD_N),
  localparam int ERASE_AW = $clog2(ERASE_BYTES),
  localparam int NBYTES   = (PTR_W + DATA_W - 1) / DATA_W,
  localparam int SEL_W    = $clog2(NBYTES + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_wr_en,
  input  logic [SEL_W-1:0]          reg_sel,
  input  logic [DATA_W-1:0]         reg_wdata,
  output logic [PTR_W-1:0]          ptr_o,
  output logic [DATA_W-1:0]         latch_o,
  input  logic                      op_req,
  input  logic                      op_is_write,
  input  logic [1:0]                op_mode,
  output logic                      busy,
  output logic                      mem_rd_en,
  output logic [PTR_W-1:0]          mem_rd_addr,
  input  logic [DATA_W-1:0]         mem_rd_data,
  output logic                      rd_valid,
  input  logic                      lwr_start,
  output logic                      lwr_issue,
  output logic [PTR_W-HOLD_AW-1:0]  lwr_block_addr,
  output logic [HOLD_N*DATA_W-1:0]  lwr_data,
  input  logic                      erase_start,
  output logic                      erase_issue,
  output logic [PTR_W-ERASE_AW-1:0] erase_block_addr
);
  logic              idle;
  logic              reg_ok;
  logic [NBYTES-1:0] byte_we;
  logic              latch_we;
  logic              step_en;
  logic              step_down;
  logic [PTR_W-1:0]  ptr_up;
  logic              hold_we;
  logic [HOLD_AW-1:0] hold_idx;

  assign reg_ok   = reg_wr_en && idle && !op_req;
  assign latch_we = reg_ok && (reg_sel == SEL_W'(NBYTES));

  for (genvar b = 0; b < NBYTES; b++) begin : g_bwe
    assign byte_we[b] = reg_ok && (reg_sel == SEL_W'(b));
  end

  tpu_ptr #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_we   (byte_we),
    .wdata     (reg_wdata),
    .step_en   (step_en),
    .step_down (step_down),
    .ptr_q     (ptr_o),
    .ptr_up    (ptr_up)
  );

  tpu_ctrl #(.PTR_W(PTR_W), .DATA_W(DATA_W), .IDX_W(HOLD_AW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_req      (op_req),
    .op_is_write (op_is_write),
    .op_mode     (op_mode),
    .ptr_q       (ptr_o),
    .ptr_up      (ptr_up),
    .mem_rd_data (mem_rd_data),
    .latch_we    (latch_we),
    .latch_wdata (reg_wdata),
    .idle        (idle),
    .acc_addr    (mem_rd_addr),
    .mem_rd_en   (mem_rd_en),
    .rd_valid    (rd_valid),
    .hold_we     (hold_we),
    .hold_idx    (hold_idx),
    .step_en     (step_en),
    .step_down   (step_down),
    .latch       (latch_o)
  );

  assign lwr_issue   = lwr_start && idle && !op_req;
  assign erase_issue = erase_start && idle && !op_req && !lwr_start;

  tpu_hold #(.HOLD_N(HOLD_N), .DATA_W(DATA_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (hold_we),
    .wr_idx  (hold_idx),
    .wr_data (latch_o),
    .refill  (lwr_issue),
    .bank    (lwr_data)
  );

  assign busy             = !idle;
  assign lwr_block_addr   = ptr_o[PTR_W-1:HOLD_AW];
  assign erase_block_addr = ptr_o[PTR_W-1:ERASE_AW];
endmodule

// File: rtl/tpu_checker.sv
`timescale 1ns/1ps
module tpu_checker #(
  parameter int PTR_W  = 22,
  parameter int DATA_W = 8,
  parameter int HOLD_N = 8,
  parameter int SEL_W  = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     op_req,
  input logic                     busy,
  input logic                     mem_rd_en,
  input logic                     rd_valid,
  input logic                     reg_wr_en,
  input logic [SEL_W-1:0]         reg_sel,
  input logic [PTR_W-1:0]         ptr_o,
  input logic                     lwr_issue,
  input logic                     erase_issue,
  input logic [HOLD_N*DATA_W-1:0] lwr_data
);
  AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy); // R5
  AST_REQ_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (op_req && !busy) |=> busy); // R5
  AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(mem_rd_en)); // R5
  AST_TOP_BIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_en && reg_sel == SEL_W'(2)) |=> $stable(ptr_o[PTR_W-1])); // R4
  AST_HOLD_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
    lwr_issue |=> (&lwr_data)); // R7
  AST_ONE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lwr_issue, erase_issue, op_req && !busy})); // R8
endmodule

bind tbl_ptr_unit tpu_checker #(
  .PTR_W(PTR_W), .DATA_W(DATA_W), .HOLD_N(HOLD_N), .SEL_W(SEL_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_req      (op_req),
  .busy        (busy),
  .mem_rd_en   (mem_rd_en),
  .rd_valid    (rd_valid),
  .reg_wr_en   (reg_wr_en),
  .reg_sel     (reg_sel),
  .ptr_o       (ptr_o),
  .lwr_issue   (lwr_issue),
  .erase_issue (erase_issue),
  .lwr_data    (lwr_data)
);

// File: tb/tbl_ptr_unit_tb.sv
`timescale 1ns/1ps
module tbl_ptr_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [7:0]  reg_wdata = '0;
  logic [21:0] ptr_o;
  logic [7:0]  latch_o;
  logic        op_req = 1'b0;
  logic        op_is_write = 1'b0;
  logic [1:0]  op_mode = '0;
  logic        busy;
  logic        mem_rd_en;
  logic [21:0] mem_rd_addr;
  logic [7:0]  mem_rd_data;
  logic        rd_valid;
  logic        lwr_start = 1'b0;
  logic        lwr_issue;
  logic [18:0] lwr_block_addr;
  logic [63:0] lwr_data;
  logic        erase_start = 1'b0;
  logic        erase_issue;
  logic [15:0] erase_block_addr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] memf(input logic [21:0] a);
    return a[7:0] ^ a[15:8] ^ {2'b00, a[21:16]} ^ 8'h5A;
  endfunction

  assign mem_rd_data = memf(mem_rd_addr);

  tbl_ptr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .ptr_o(ptr_o), .latch_o(latch_o), .op_req(op_req),
    .op_is_write(op_is_write), .op_mode(op_mode), .busy(busy),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .rd_valid(rd_valid), .lwr_start(lwr_start), .lwr_issue(lwr_issue),
    .lwr_block_addr(lwr_block_addr), .lwr_data(lwr_data),
    .erase_start(erase_start), .erase_issue(erase_issue),
    .erase_block_addr(erase_block_addr)
  );

  typedef struct packed {
    logic [21:0] start;
    logic [1:0]  mode;
    logic [21:0] acc;
    logic [21:0] fin;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{22'h000010, 2'd0, 22'h000010, 22'h000010},
    '{22'h000010, 2'd1, 22'h000010, 22'h000011},
    '{22'h000010, 2'd2, 22'h000010, 22'h00000F},
    '{22'h000010, 2'd3, 22'h000011, 22'h000011},
    '{22'h1FFFFF, 2'd1, 22'h1FFFFF, 22'h000000},
    '{22'h3FFFFF, 2'd3, 22'h200000, 22'h200000},
    '{22'h200000, 2'd2, 22'h200000, 22'h3FFFFF},
    '{22'h000000, 2'd2, 22'h000000, 22'h1FFFFF},
    '{22'h2ABCDE, 2'd0, 22'h2ABCDE, 22'h2ABCDE}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic set_ptr(input logic [21:0] p);
    reg_write(2'd0, p[7:0]);
    reg_write(2'd1, p[15:8]);
    reg_write(2'd2, {2'b00, p[21:16]});
  endtask

  // Returns the address seen on mem_rd_addr in the busy cycle
  task automatic do_op(input logic wr, input logic [1:0] mode, output logic [21:0] seen,
                       output logic seen_en, output logic seen_busy);
    @(negedge clk);
    op_req = 1'b1; op_is_write = wr; op_mode = mode;
    @(negedge clk);
    op_req = 1'b0;
    seen = mem_rd_addr; seen_en = mem_rd_en; seen_busy = busy;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [21:0] seen;
    logic        seen_en;
    logic        seen_busy;
    logic [63:0] exp_bank;

    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ptr", 64'(ptr_o), 64'h0);
    check("R1 latch", 64'(latch_o), 64'h0);
    check("R1 holding", lwr_data, {64{1'b1}});
    check("R1 busy", 64'(busy), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 register loads
    set_ptr(22'h2ABCDE);
    check("R2 ptr bytes", 64'(ptr_o), 64'h2ABCDE);
    reg_write(2'd3, 8'hC3);
    check("R2 latch", 64'(latch_o), 64'hC3);

    // Vector table: reads under every mode, wrap corners (R3 R4 R5 R9)
    for (int i = 0; i < NV; i++) begin
      set_ptr(VECS[i].start);
      do_op(1'b0, VECS[i].mode, seen, seen_en, seen_busy);
      check("R5 busy in access", 64'(seen_busy), 64'h1);
      check("R5 rd_en", 64'(seen_en), 64'h1);
      check("R3 access addr", 64'(seen), 64'(VECS[i].acc));
      check("R5 latch data", 64'(latch_o), 64'(memf(VECS[i].acc)));
      check("R5 rd_valid", 64'(rd_valid), 64'h1);
      check("R4 R9 final ptr", 64'(ptr_o), 64'(VECS[i].fin));
    end

    // R5 request held through busy cycle is ignored; R2 reg write while busy ignored
    set_ptr(22'h000040);
    @(negedge clk);
    op_req = 1'b1; op_is_write = 1'b0; op_mode = 2'd1;
    @(negedge clk);
    reg_wr_en = 1'b1; reg_sel = 2'd0; reg_wdata = 8'hEE;
    @(negedge clk);
    op_req = 1'b0; reg_wr_en = 1'b0;
    check("R5 one busy cycle", 64'(busy), 64'h0);
    check("R2 write ignored while busy", 64'(ptr_o), 64'h000041);
    check("R5 latch after held req", 64'(latch_o), 64'(memf(22'h000040)));
    @(negedge clk);

    // R6 table writes into holding registers, post-increment through one block
    set_ptr(22'h000100);
    exp_bank = '0;
    for (int k = 0; k < 8; k++) begin
      reg_write(2'd3, 8'h10 + 8'(k));
      do_op(1'b1, 2'd1, seen, seen_en, seen_busy);
      exp_bank[k*8 +: 8] = 8'h10 + 8'(k);
      check("R6 no rd_en on write", 64'(seen_en), 64'h0);
      check("R6 no rd_valid", 64'(rd_valid), 64'h0);
    end
    check("R6 holding bank", lwr_data, exp_bank);
    check("R6 ptr after writes", 64'(ptr_o), 64'h000108);

    // R6 pre-increment write wraps index 7 -> 0
    set_ptr(22'h000107);
    reg_write(2'd3, 8'hA5);
    do_op(1'b1, 2'd3, seen, seen_en, seen_busy);
    exp_bank[7:0] = 8'hA5;
    check("R6 preinc index", lwr_data, exp_bank);

    // R8 priority: op_req over lwr_start
    @(negedge clk);
    op_req = 1'b1; op_mode = 2'd0; op_is_write = 1'b0; lwr_start = 1'b1;
    #1;
    check("R8 op beats lwr", 64'(lwr_issue), 64'h0);
    @(negedge clk);
    op_req = 1'b0; lwr_start = 1'b0;
    @(negedge clk);

    // R7 long write issue
    lwr_start = 1'b1; erase_start = 1'b1;
    #1;
    check("R7 lwr_issue", 64'(lwr_issue), 64'h1);
    check("R8 lwr beats erase", 64'(erase_issue), 64'h0);
    check("R7 block addr", 64'(lwr_block_addr), 64'(22'h000108 >> 3));
    check("R7 data", lwr_data, exp_bank);
    @(negedge clk);
    lwr_start = 1'b0; erase_start = 1'b0;
    check("R7 refill", lwr_data, {64{1'b1}});

    // R8 erase
    set_ptr(22'h2ABCDE);
    @(negedge clk);
    erase_start = 1'b1;
    #1;
    check("R8 erase_issue", 64'(erase_issue), 64'h1);
    check("R8 erase addr", 64'(erase_block_addr), 64'(22'h2ABCDE >> 6));
    @(negedge clk);
    erase_start = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule